// File: doc/BRIEF.md
# Filtered Fabric Traffic Counter

This block sits beside a request stream at a last-level-cache and memory port and keeps five event totals: read requests, write requests, bytes moved by reads, bytes moved by writes, and elapsed cycles. One read request and one write request can be presented in the same cycle, on two separate input channels. Each request carries a byte count plus two class tags computed upstream. The source tag says who issued the request. The destination tag names the home socket and memory type of the target address.

A single configuration write sets two groups of class-enable bits, a run bit and a clear bit. A request is counted only when its source tag is enabled and its destination tag is enabled. A group left at all zeros lets every class through in that dimension. Software reads any total through a select/data read port and derives bandwidth and request rates itself.

Counting is governed by a two-state controller. In `ST_IDLE` nothing advances. In `ST_RUN` the cycle total advances every clock and qualified requests are added. A configuration write whose run bit is 1 moves the controller from `ST_IDLE` to `ST_RUN`. A configuration write whose run bit is 0 moves it from `ST_RUN` back to `ST_IDLE`. Any other cycle leaves the state where it is.

Top module: `fabric_traffic_monitor`

## Requirements
- R1: After reset every total reads zero, and the controller is in `ST_IDLE`, so no total advances until a configuration write sets the run bit.
- R2: While running, the cycle total (select 4) advances by one at every clock edge.
- R3: While running, a qualified read adds one to the read-request total (select 0) and adds `rd_len` to the read-byte total (select 2) at the same clock edge.
- R4: While running, a qualified write adds one to the write-request total (select 1) and adds `wr_len` to the write-byte total (select 3) at the same clock edge.
- R5: A qualified read and a qualified write in the same cycle are both counted.
- R6: Source enables are `cfg_wdata[2:0]`. Bit 0 enables code 0 (local CPU), bit 1 enables code 1 (local non-CPU device), and bit 2 enables code 2 (remote socket). Source code 3 passes only when all three bits are zero. When all three bits are zero, every source passes.
- R7: Destination enables are `cfg_wdata[6:3]`. Bit 3+n enables destination code n: 0 is local system memory, 1 is local GPU memory, 2 is local other (CXL) memory, and 3 is remote memory. When all four bits are zero, every destination passes.
- R8: A request is counted only when it passes both the source check and the destination check.
- R9: While not running, no total changes, whatever traffic arrives.
- R10: A configuration write with `cfg_wdata[8]` set zeroes all five totals at that clock edge. This overrides any increment due at the same edge.
- R11: With `SATURATE`=1, a total stops at its all-ones value. With `SATURATE`=0, it wraps modulo 2^`CNT_W`.
- R12: A configuration write (run bit `cfg_wdata[7]`) affects counting from the next edge onward; requests in the write cycle itself use the previous settings. `cnt_sel` values 5 to 7 read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_wdata | input | 9 | {clear, run, dst enables[3:0], src enables[2:0]} |
| rd_vld | input | 1 | Read request present |
| rd_len | input | BYTE_W | Bytes moved by the read |
| rd_src | input | 2 | Read source class code |
| rd_dst | input | 2 | Read destination class code |
| wr_vld | input | 1 | Write request present |
| wr_len | input | BYTE_W | Bytes moved by the write |
| wr_src | input | 2 | Write source class code |
| wr_dst | input | 2 | Write destination class code |
| cnt_sel | input | 3 | Total to read (0..4) |
| cnt_rdata | output | CNT_W | Selected total, combinational |

## Verification
The bench sweeps every combination of source and destination enable groups: all 8 source settings and all 16 destination settings. Under each setting it drives all 16 read class pairs, with a write of a different class pair in the same cycle. A filter that treated an empty group as "block all", indexed the reserved source code into the enable bits, or combined the two checks with OR would produce wrong totals somewhere in that sweep. Each configuration write carries a live request. A design that let that request see the new settings, or let it survive a clear, is therefore caught. Long bursts then overflow 8-bit totals in a saturating copy and a wrapping copy, exposing a counter that wraps when it should stick, or sticks when it should wrap.

// File: rtl/ftm_pkg.sv
package ftm_pkg;
    localparam int NUM_SRC   = 3;
    localparam int NUM_DST   = 4;
    localparam int CLS_W     = 2;
    localparam int CFG_W     = 9;
    localparam int SRC_LSB   = 0;
    localparam int DST_LSB   = SRC_LSB + NUM_SRC;
    localparam int RUN_BIT   = DST_LSB + NUM_DST;
    localparam int CLR_BIT   = RUN_BIT + 1;
    localparam int NUM_CNT   = 5;
    localparam int SEL_W     = 3;

    localparam int IDX_RDREQ  = 0;
    localparam int IDX_WRREQ  = 1;
    localparam int IDX_RDBYTE = 2;
    localparam int IDX_WRBYTE = 3;
    localparam int IDX_CYCLE  = 4;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_RUN  = 1'b1
    } mon_state_e;
endpackage

// File: rtl/ftm_ctrl_fsm.sv
module ftm_ctrl_fsm
    import ftm_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic cfg_we,
    input  logic cfg_run,
    input  logic cfg_clr,
    output logic count_en,
    output logic clr_pulse
);
    mon_state_e state_q;
    mon_state_e state_d;

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (cfg_we && cfg_run)  state_d = ST_RUN;
            ST_RUN:  if (cfg_we && !cfg_run) state_d = ST_IDLE;
        endcase
    end

    always_comb begin
        clr_pulse = cfg_we && cfg_clr;
        unique case (state_q)
            ST_IDLE: count_en = 1'b0;
            ST_RUN:  count_en = 1'b1;
        endcase
    end

    // R12: the run bit takes effect at the edge of the write
    assert_start_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_we && cfg_run) |=> count_en);
    assert_stop_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_we && !cfg_run) |=> !count_en);
    assert_keep_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_we |=> $stable(count_en));
endmodule

// File: rtl/ftm_class_qual.sv
module ftm_class_qual
    import ftm_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               vld,
    input  logic [CLS_W-1:0]   src,
    input  logic [CLS_W-1:0]   dst,
    input  logic [NUM_SRC-1:0] src_en,
    input  logic [NUM_DST-1:0] dst_en,
    output logic               hit
);
    logic src_ok;
    logic dst_ok;

    always_comb begin
        src_ok = (src_en == '0);
        for (int i = 0; i < NUM_SRC; i++) begin
            if (int'(src) == i && src_en[i]) src_ok = 1'b1;
        end
        dst_ok = (dst_en == '0);
        for (int j = 0; j < NUM_DST; j++) begin
            if (int'(dst) == j && dst_en[j]) dst_ok = 1'b1;
        end
        hit = vld && src_ok && dst_ok;
    end

    // R6/R7: empty enable groups let every request through
    assert_open_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (vld && src_en == '0 && dst_en == '0) |-> hit);
    // R6: reserved source code is blocked once any source bit is set
    assert_rsvd_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (src_en != '0 && int'(src) >= NUM_SRC) |-> !hit);
    // R8: nothing counts without a request
    assert_needvld_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !vld |-> !hit);
endmodule

// File: rtl/ftm_counter.sv
module ftm_counter #(
    parameter int CNT_W = 32,
    parameter int INC_W = 8,
    parameter bit SAT   = 1'b1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             en,
    input  logic [INC_W-1:0] inc,
    output logic [CNT_W-1:0] cnt
);
    localparam int SUM_W = CNT_W + 1;

    logic [SUM_W-1:0] sum;
    logic [CNT_W-1:0] nxt;

    always_comb begin
        sum = {1'b0, cnt} + SUM_W'(inc);
        if (SAT && sum[CNT_W]) nxt = '1;
        else                   nxt = sum[CNT_W-1:0];
    end

    always_ff @(posedge clk) begin
        if (!rst_n)   cnt <= '0;
        else if (clr) cnt <= '0;
        else if (en)  cnt <= nxt;
    end

    assert_clear_R10: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (cnt == '0));
    assert_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr && !en) |=> $stable(cnt));
    assert_stick_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (SAT && !clr && cnt == '1) |=> (cnt == '1));
    assert_wrap_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (!SAT && en && !clr) |=> (cnt == $past(cnt) + CNT_W'($past(inc))));
endmodule

// File: rtl/fabric_traffic_monitor.sv
module fabric_traffic_monitor
    import ftm_pkg::*;
#(
    parameter int CNT_W    = 32,
    parameter int BYTE_W   = 8,
    parameter bit SATURATE = 1'b1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [8:0]        cfg_wdata,
    input  logic              rd_vld,
    input  logic [BYTE_W-1:0] rd_len,
    input  logic [1:0]        rd_src,
    input  logic [1:0]        rd_dst,
    input  logic              wr_vld,
    input  logic [BYTE_W-1:0] wr_len,
    input  logic [1:0]        wr_src,
    input  logic [1:0]        wr_dst,
    input  logic [2:0]        cnt_sel,
    output logic [CNT_W-1:0]  cnt_rdata
);
    logic [NUM_SRC-1:0] src_en_q;
    logic [NUM_DST-1:0] dst_en_q;
    logic               count_en;
    logic               clr_pulse;
    logic               rd_hit;
    logic               wr_hit;
    logic [BYTE_W-1:0]  inc_v [NUM_CNT];
    logic [CNT_W-1:0]   cnt_q [NUM_CNT];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            src_en_q <= '0;
            dst_en_q <= '0;
        end else if (cfg_we) begin
            src_en_q <= cfg_wdata[SRC_LSB +: NUM_SRC];
            dst_en_q <= cfg_wdata[DST_LSB +: NUM_DST];
        end
    end

    ftm_ctrl_fsm u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg_we    (cfg_we),
        .cfg_run   (cfg_wdata[RUN_BIT]),
        .cfg_clr   (cfg_wdata[CLR_BIT]),
        .count_en  (count_en),
        .clr_pulse (clr_pulse)
    );

    ftm_class_qual u_rd_qual (
        .clk (clk), .rst_n (rst_n), .vld (rd_vld),
        .src (rd_src), .dst (rd_dst),
        .src_en (src_en_q), .dst_en (dst_en_q), .hit (rd_hit)
    );

    ftm_class_qual u_wr_qual (
        .clk (clk), .rst_n (rst_n), .vld (wr_vld),
        .src (wr_src), .dst (wr_dst),
        .src_en (src_en_q), .dst_en (dst_en_q), .hit (wr_hit)
    );

    always_comb begin
        inc_v[IDX_RDREQ]  = BYTE_W'(rd_hit);
        inc_v[IDX_WRREQ]  = BYTE_W'(wr_hit);
        inc_v[IDX_RDBYTE] = rd_hit ? rd_len : '0;
        inc_v[IDX_WRBYTE] = wr_hit ? wr_len : '0;
        inc_v[IDX_CYCLE]  = BYTE_W'(1);
    end

    for (genvar k = 0; k < NUM_CNT; k++) begin : g_cnt
        ftm_counter #(
            .CNT_W (CNT_W),
            .INC_W (BYTE_W),
            .SAT   (SATURATE)
        ) u_cnt (
            .clk   (clk),
            .rst_n (rst_n),
            .clr   (clr_pulse),
            .en    (count_en),
            .inc   (inc_v[k]),
            .cnt   (cnt_q[k])
        );
    end

    always_comb begin
        cnt_rdata = '0;
        for (int k = 0; k < NUM_CNT; k++) begin
            if (int'(cnt_sel) == k) cnt_rdata = cnt_q[k];
        end
    end

    // R3: an unqualified read leaves the read-request total alone
    assert_rdquiet_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr_pulse && !rd_hit) |=> $stable(cnt_q[IDX_RDREQ]));
    // R4: same for writes
    assert_wrquiet_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr_pulse && !wr_hit) |=> $stable(cnt_q[IDX_WRREQ]));
    // R2: a running saturating cycle total is never zero after an edge
    assert_cycle_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (SATURATE && count_en && !clr_pulse) |=> (cnt_q[IDX_CYCLE] != '0));
    // R12: unused selects read zero
    assert_sel_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (int'(cnt_sel) >= NUM_CNT) |-> (cnt_rdata == '0));
endmodule

// File: tb/tb_fabric_traffic_monitor.sv
module tb_fabric_traffic_monitor;
    localparam int CW   = 8;
    localparam int BW   = 6;
    localparam int MAXV = (1 << CW) - 1;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cfg_we = 1'b0;
    logic [8:0]    cfg_wdata = '0;
    logic          rd_vld = 1'b0;
    logic [BW-1:0] rd_len = '0;
    logic [1:0]    rd_src = '0;
    logic [1:0]    rd_dst = '0;
    logic          wr_vld = 1'b0;
    logic [BW-1:0] wr_len = '0;
    logic [1:0]    wr_src = '0;
    logic [1:0]    wr_dst = '0;
    logic [2:0]    cnt_sel = '0;
    logic [CW-1:0] rdata_s;
    logic [CW-1:0] rdata_w;

    int n_cmp = 0;
    int n_bad = 0;
    bit done = 1'b0;

    int es [5];
    int ew [5];
    bit m_run = 1'b0;
    int m_src = 0;
    int m_dst = 0;

    always #5 clk = ~clk;

    fabric_traffic_monitor #(.CNT_W(CW), .BYTE_W(BW), .SATURATE(1'b1)) dut (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
        .rd_vld(rd_vld), .rd_len(rd_len), .rd_src(rd_src), .rd_dst(rd_dst),
        .wr_vld(wr_vld), .wr_len(wr_len), .wr_src(wr_src), .wr_dst(wr_dst),
        .cnt_sel(cnt_sel), .cnt_rdata(rdata_s)
    );

    fabric_traffic_monitor #(.CNT_W(CW), .BYTE_W(BW), .SATURATE(1'b0)) dut_wrap (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
        .rd_vld(rd_vld), .rd_len(rd_len), .rd_src(rd_src), .rd_dst(rd_dst),
        .wr_vld(wr_vld), .wr_len(wr_len), .wr_src(wr_src), .wr_dst(wr_dst),
        .cnt_sel(cnt_sel), .cnt_rdata(rdata_w)
    );

    task automatic report();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    endtask

    task automatic chk(input string req, input string what, input int got, input int exp);
        n_cmp++;
        if (got != exp) begin
            n_bad++;
            $display("FAIL %s %s: got %0d expected %0d", req, what, got, exp);
        end
    endtask

    // R6 R7 R8 model of qualification
    function automatic bit m_qual(input int s, input int d);
        bit s_ok = (m_src == 0) || (s < 3 && m_src[s]);
        bit d_ok = (m_dst == 0) || m_dst[d];
        return s_ok && d_ok;
    endfunction

    task automatic m_add(input int k, input int inc);
        es[k] = (es[k] + inc > MAXV) ? MAXV : es[k] + inc;
        ew[k] = (ew[k] + inc) % (MAXV + 1);
    endtask

    task automatic m_edge(input bit rv, input int rl, input int rs, input int rd,
                          input bit wv, input int wl, input int ws, input int wd,
                          input bit clr);
        if (clr) begin
            for (int k = 0; k < 5; k++) begin es[k] = 0; ew[k] = 0; end
        end else if (m_run) begin
            m_add(4, 1);
            if (rv && m_qual(rs, rd)) begin m_add(0, 1); m_add(2, rl); end
            if (wv && m_qual(ws, wd)) begin m_add(1, 1); m_add(3, wl); end
        end
    endtask

    task automatic traffic(input bit rv, input int rl, input int rs, input int rd,
                           input bit wv, input int wl, input int ws, input int wd);
        @(negedge clk);
        cfg_we = 1'b0;
        rd_vld = rv; rd_len = BW'(rl); rd_src = 2'(rs); rd_dst = 2'(rd);
        wr_vld = wv; wr_len = BW'(wl); wr_src = 2'(ws); wr_dst = 2'(wd);
        m_edge(rv, rl, rs, rd, wv, wl, ws, wd, 1'b0);
    endtask

    // configuration write with a live read request (class 0/0, 5 bytes)
    task automatic cfg_write(input int s, input int d, input bit run, input bit clr);
        @(negedge clk);
        cfg_we = 1'b1;
        cfg_wdata = {clr, run, 4'(d), 3'(s)};
        rd_vld = 1'b1; rd_len = BW'(5); rd_src = 2'd0; rd_dst = 2'd0;
        wr_vld = 1'b0;
        m_edge(1'b1, 5, 0, 0, 1'b0, 0, 0, 0, clr);
        m_run = run; m_src = s; m_dst = d;
    endtask

    task automatic check_all(input string req);
        for (int k = 0; k < 5; k++) begin
            @(negedge clk);
            cfg_we = 1'b0; rd_vld = 1'b0; wr_vld = 1'b0;
            cnt_sel = 3'(k);
            #1;
            chk(req, $sformatf("sat total %0d", k), int'(rdata_s), es[k]);
            chk(req, $sformatf("wrap total %0d", k), int'(rdata_w), ew[k]);
            m_edge(1'b0, 0, 0, 0, 1'b0, 0, 0, 0, 1'b0);
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_cmp++; n_bad++;
            $display("FAIL watchdog: got timeout expected completion");
            report();
            $finish;
        end
    end

    initial begin
        for (int k = 0; k < 5; k++) begin es[k] = 0; ew[k] = 0; end
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;

        // R1: reset state, and idle traffic does not count
        traffic(1'b1, 7, 0, 0, 1'b1, 9, 1, 1);
        check_all("R1");

        // R2 R3 R4 R5 R6 R7 R8 R10 R12: sweep every enable combination
        for (int sm = 0; sm < 8; sm++) begin
            for (int dm = 0; dm < 16; dm++) begin
                cfg_write(sm, dm, 1'b1, 1'b1);
                for (int s = 0; s < 4; s++) begin
                    for (int d = 0; d < 4; d++) begin
                        traffic(1'b1, 1 + s + d, s, d,
                                1'b1, 2 + d, 3 - s, (d + 1) % 4);
                    end
                end
                check_all("R2 R3 R4 R5 R6 R7 R8 R10 R12");
            end
        end

        // R9: stop (no clear), then traffic must leave totals untouched
        cfg_write(0, 0, 1'b0, 1'b0);
        for (int i = 0; i < 8; i++) traffic(1'b1, 11, 0, 0, 1'b1, 13, 2, 3);
        check_all("R9");

        // R12: new settings apply after the write edge, old ones before it
        cfg_write(3'b001, 0, 1'b1, 1'b1);
        cfg_write(3'b010, 0, 1'b1, 1'b0);
        traffic(1'b1, 3, 1, 2, 1'b1, 4, 0, 2);
        check_all("R12");

        // R11: overflow in saturating and wrapping copies
        cfg_write(0, 0, 1'b1, 1'b1);
        for (int i = 0; i < 10; i++) traffic(1'b1, 63, 2, 3, 1'b1, 40, 1, 2);
        for (int i = 0; i < 300; i++) traffic(1'b0, 0, 0, 0, 1'b0, 0, 0, 0);
        check_all("R11");

        // R12: out-of-range selects read zero
        for (int k = 5; k < 8; k++) begin
            @(negedge clk);
            cnt_sel = 3'(k);
            #1;
            chk("R12", $sformatf("sat select %0d", k), int'(rdata_s), 0);
            chk("R12", $sformatf("wrap select %0d", k), int'(rdata_w), 0);
            m_edge(1'b0, 0, 0, 0, 1'b0, 0, 0, 0, 1'b0);
        end

        // R10: clear coinciding with a live request leaves all zero
        cfg_write(0, 0, 1'b0, 1'b1);
        check_all("R10");

        done = 1'b1;
        report();
        $finish;
    end
endmodule